// File: doc/BRIEF.md
# Infrared Carrier Period and Duty Meter

This block sits behind the raw, still-modulated infrared input of a remote-control receiver. It runs when the receiver is in wideband (learning) mode. It measures the carrier one cycle at a time, from one rising edge to the next. A prescaler derives a measurement tick from the system clock. At the default setting the tick is 2 MHz, so one count equals 500 ns. Two counters run between edges: one counts the ticks of the whole cycle, and the other counts only the ticks during which the input is high.

When a full cycle closes without either counter running out of range, both counts are copied into two host-visible registers and a valid flag is raised. The valid flag is the top bit of the period register. Firmware divides 2,000,000 by the period count to get the carrier frequency in Hz. It divides the high count times 100 by the period count to get the duty cycle in percent. Firmware clears the flag by signalling a read of the period register. The next complete carrier cycle sets the flag again. A separate enable input turns the whole measurement on and off.

Top module: `ir_carrier_meter`

## Requirements
- R1: After reset, both `period_reg` and `high_reg` read as zero.
- R2: When two successive rising edges of the input are P ticks apart, with 1 <= P <= 2^CNT_W-1, `period_reg` holds P in bits [CNT_W-1:0] and bit CNT_W (valid) reads 1. A later complete cycle overwrites the earlier result.
- R3: For that same cycle, `high_reg` bits [CNT_W-1:0] hold the number of ticks during which the input was high, and bit CNT_W of `high_reg` is always 0. The high count never exceeds the period count while valid is set.
- R4: The first rising edge after reset, or after `det_en` goes high, only starts a measurement. It latches nothing.
- R5: A cycle that lasts longer than 2^CNT_W-1 ticks is discarded. The stored counts and the valid bit keep their previous values, and the rising edge that ends such a cycle starts a fresh measurement.
- R6: A period count of zero is never latched, so valid=1 always comes with a nonzero period.
- R7: A one-cycle pulse on `rd_period` clears the valid bit and leaves both counts unchanged. The next complete carrier cycle sets the valid bit again. If a new result is latched in the same cycle as the read, the new result wins and valid stays 1.
- R8: While `det_en` is low, the valid bit is held at 0, carrier edges are ignored, and the stored counts do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ir_in | input | 1 | Raw modulated infrared input, asynchronous to clk |
| det_en | input | 1 | Carrier measurement enable (learning mode) |
| rd_period | input | 1 | One-cycle strobe marking a host read of the period register |
| period_reg | output | CNT_W+1 | {valid, period count in ticks} |
| high_reg | output | CNT_W+1 | {1'b0, high-time count in ticks} |

## Verification
The bench builds the block with TICK_DIV=1, so every clock cycle is one tick and the expected counts equal the exact number of cycles the bench holds the input high and low. CNT_W is kept at 7 and SYNC_STAGES at 2, the default width. With these values the saturation edge is cheap to reach: a 127-cycle period must latch and a 128-cycle period must be dropped. Random periods from 2 to 127 with random high times are mixed with directed cases for reads, disable and re-arming.

// File: rtl/ir_meter_pkg.sv
package ir_meter_pkg;
  localparam int unsigned IRM_CNT_W_DEF    = 7;
  localparam int unsigned IRM_TICK_DIV_DEF = 50;
  localparam int unsigned IRM_SYNC_DEF     = 2;

  // Measurement state of the cycle counters
  typedef enum logic [1:0] {
    MS_IDLE = 2'd0,  // waiting for first edge after enable
    MS_RUN  = 2'd1,  // counting a cycle that started at a rising edge
    MS_OVER = 2'd2   // cycle exceeded counter range, wait for next edge
  } meas_st_e;
endpackage

// File: rtl/ir_meter_sync.sv
module ir_meter_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lvl,
  output logic rise
);
  logic [STAGES-1:0] sh_q, sh_d;
  logic              prev_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      assign sh_d[i] = din;
    end else begin : g_next
      assign sh_d[i] = sh_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign lvl  = sh_q[STAGES-1];
  assign rise = sh_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/ir_meter_tbase.sv
module ir_meter_tbase #(
  parameter int unsigned DIV = 50
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  if (DIV <= 1) begin : g_every
    assign tick = 1'b1;
  end else begin : g_div
    localparam int unsigned DW = $clog2(DIV);
    localparam logic [DW-1:0] LAST = DW'(DIV - 1);
    logic [DW-1:0] div_q, div_d;

    always_comb begin
      tick  = (div_q == LAST);
      div_d = tick ? '0 : div_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) div_q <= '0;
      else        div_q <= div_d;
    end
  end
endmodule

// File: rtl/ir_meter_count.sv
module ir_meter_count
  import ir_meter_pkg::*;
#(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic             lvl,
  input  logic             rise,
  output logic             done,
  output logic [CNT_W-1:0] per_o,
  output logic [CNT_W-1:0] hi_o
);
  localparam logic [CNT_W-1:0] CMAX = '1;
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  meas_st_e         st_q, st_d;
  logic [CNT_W-1:0] per_q, per_d, hi_q, hi_d;

  always_comb begin
    st_d  = st_q;
    per_d = per_q;
    hi_d  = hi_q;
    done  = 1'b0;
    if (!en) begin
      st_d  = MS_IDLE;
      per_d = '0;
      hi_d  = '0;
    end else if (rise) begin
      // a cycle closes here; only a clean in-range cycle reports
      done  = (st_q == MS_RUN) && (per_q != '0);
      st_d  = MS_RUN;
      per_d = tick ? ONE : '0;
      hi_d  = tick ? ONE : '0;
    end else if (tick && st_q == MS_RUN) begin
      if (per_q == CMAX) st_d  = MS_OVER;
      else               per_d = per_q + ONE;
      if (lvl && hi_q != CMAX) hi_d = hi_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= MS_IDLE;
      per_q <= '0;
      hi_q  <= '0;
    end else begin
      st_q  <= st_d;
      per_q <= per_d;
      hi_q  <= hi_d;
    end
  end

  assign per_o = per_q;
  assign hi_o  = hi_q;
endmodule

// File: rtl/ir_carrier_meter.sv
module ir_carrier_meter
  import ir_meter_pkg::*;
#(
  parameter int unsigned TICK_DIV    = IRM_TICK_DIV_DEF,
  parameter int unsigned CNT_W       = IRM_CNT_W_DEF,
  parameter int unsigned SYNC_STAGES = IRM_SYNC_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ir_in,
  input  logic             det_en,
  input  logic             rd_period,
  output logic [CNT_W:0]   period_reg,
  output logic [CNT_W:0]   high_reg
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sh_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh_q <= 2'b00;
    else        rst_sh_q <= {rst_sh_q[0], 1'b1};
  end
  assign rst_int_n = rst_sh_q[1];

  logic             in_lvl, in_rise, tick, meas_done;
  logic [CNT_W-1:0] per_c, hi_c;

  ir_meter_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .din(ir_in), .lvl(in_lvl), .rise(in_rise)
  );

  ir_meter_tbase #(.DIV(TICK_DIV)) u_tbase (
    .clk(clk), .rst_n(rst_int_n), .tick(tick)
  );

  ir_meter_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_int_n), .en(det_en), .tick(tick),
    .lvl(in_lvl), .rise(in_rise), .done(meas_done),
    .per_o(per_c), .hi_o(hi_c)
  );

  // host-visible result registers
  logic [CNT_W-1:0] per_lat_q, hi_lat_q;
  logic             vld_q, vld_d, vld_en, lat_en;

  always_comb begin
    lat_en = meas_done;
    vld_en = meas_done | rd_period | ~det_en;
    vld_d  = meas_done;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      per_lat_q <= '0;
      hi_lat_q  <= '0;
    end else if (lat_en) begin
      per_lat_q <= per_c;
      hi_lat_q  <= hi_c;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  vld_q <= 1'b0;
    else if (vld_en) vld_q <= vld_d;
  end

  assign period_reg = {vld_q, per_lat_q};
  assign high_reg   = {1'b0, hi_lat_q};
endmodule

// File: rtl/ir_carrier_meter_chk.sv
module ir_carrier_meter_chk #(
  parameter int unsigned CNT_W = 7
) (
  input logic           clk,
  input logic           rst_n,
  input logic           det_en,
  input logic           rd_period,
  input logic           meas_done,
  input logic [CNT_W:0] period_reg,
  input logic [CNT_W:0] high_reg
);
  AST_VALID_FROM_MEAS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(period_reg[CNT_W]) |-> $past(meas_done)); // R2
  AST_HIGH_WITHIN: assert property (@(posedge clk) disable iff (!rst_n)
    period_reg[CNT_W] |-> (high_reg[CNT_W-1:0] <= period_reg[CNT_W-1:0])); // R3
  AST_HOLD_NO_MEAS: assert property (@(posedge clk) disable iff (!rst_n)
    !meas_done |=> ($stable(period_reg[CNT_W-1:0]) && $stable(high_reg))); // R5
  AST_ZERO_NOT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    period_reg[CNT_W] |-> (period_reg[CNT_W-1:0] != '0)); // R6
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_period && !meas_done) |=> !period_reg[CNT_W]); // R7
  AST_OFF_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !det_en |=> !period_reg[CNT_W]); // R8
endmodule

bind ir_carrier_meter ir_carrier_meter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .det_en(det_en), .rd_period(rd_period),
  .meas_done(meas_done), .period_reg(period_reg), .high_reg(high_reg)
);

// File: tb/ir_carrier_meter_tb.sv
module ir_carrier_meter_tb;
  localparam int unsigned CNT_W = 7;
  localparam int unsigned PMAX  = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ir_in = 1'b0;
  logic det_en = 1'b0;
  logic rd_period = 1'b0;
  logic [CNT_W:0] period_reg, high_reg;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  ir_carrier_meter #(.TICK_DIV(1), .CNT_W(CNT_W), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .ir_in(ir_in), .det_en(det_en),
    .rd_period(rd_period), .period_reg(period_reg), .high_reg(high_reg)
  );

  function automatic logic [CNT_W:0] exp_per(input logic v, input int p);
    return {v, CNT_W'(p)};
  endfunction

  function automatic logic [CNT_W:0] exp_hi(input int h);
    return {1'b0, CNT_W'(h)};
  endfunction

  task automatic check(input string req, input logic [CNT_W:0] ep, input logic [CNT_W:0] eh);
    checks++;
    if (period_reg !== ep || high_reg !== eh) begin
      errors++;
      $display("FAIL %s: period=%h high=%h expected period=%h high=%h",
               req, period_reg, high_reg, ep, eh);
    end
    checks++;
    if (period_reg[CNT_W] && period_reg[CNT_W-1:0] == '0) begin
      errors++;
      $display("FAIL R6: period=%h expected nonzero count with valid", period_reg);
    end
  endtask

  // drive n carrier cycles of p clocks with h clocks high, then a long low tail
  task automatic carrier(input int p, input int h, input int n);
    for (int c = 0; c < n; c++) begin
      for (int k = 0; k < p; k++) begin
        @(negedge clk);
        ir_in = (k < h);
      end
    end
    @(negedge clk);
    ir_in = 1'b0;
    repeat (PMAX + 16) @(negedge clk);
  endtask

  task automatic host_read();
    @(negedge clk);
    rd_period = 1'b1;
    @(negedge clk);
    rd_period = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    check("R1", '0, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", '0, '0);

    det_en = 1'b1;
    carrier(12, 6, 1);              // one edge only: R4
    check("R4", '0, '0);

    carrier(10, 5, 3);              // R2 R3
    check("R2", exp_per(1, 10), exp_hi(5));

    carrier(PMAX, 1, 2);            // largest in-range period: R5 boundary
    check("R5", exp_per(1, PMAX), exp_hi(1));

    carrier(2, 1, 3);               // shortest period
    check("R2", exp_per(1, 2), exp_hi(1));

    carrier(PMAX + 1, 64, 3);       // out of range, discarded: R5
    check("R5", exp_per(1, 2), exp_hi(1));

    host_read();                    // R7 clear-on-read
    check("R7", exp_per(0, 2), exp_hi(1));
    carrier(20, 7, 2);
    check("R7", exp_per(1, 20), exp_hi(7));

    @(negedge clk);
    det_en = 1'b0;                  // R8
    repeat (2) @(negedge clk);
    check("R8", exp_per(0, 20), exp_hi(7));
    carrier(30, 10, 3);
    check("R8", exp_per(0, 20), exp_hi(7));

    det_en = 1'b1;
    carrier(40, 13, 1);             // first edge after enable: R4
    check("R4", exp_per(0, 20), exp_hi(7));
    carrier(30, 10, 2);
    check("R3", exp_per(1, 30), exp_hi(10));

    for (int i = 0; i < 24; i++) begin
      int p, h, n;
      p = $urandom_range(PMAX, 2);
      h = $urandom_range(p - 1, 1);
      n = $urandom_range(3, 2);
      carrier(p, h, n);
      check("R2", exp_per(1, p), exp_hi(h));
      if (i % 6 == 5) begin
        host_read();
        check("R7", exp_per(0, p), exp_hi(h));
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule